// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block keeps an event flag and an enable bit for each of sixteen message buffers in a CAN-style controller. The buffer logic pulses one line per buffer when a frame on that buffer is sent or received. The pulse latches the buffer's flag. The block raises a single interrupt request whenever any flag meets a set enable bit. The event flags and the enables are two 16-bit registers. A small register port reaches them, one byte lane at a time or both lanes together.

Software cannot clear a flag with a blind write. It must first read the flag and see a one. Only then does a write of zero to that bit clear it. A new event on the buffer between that read and that write cancels the pending clear. An event that arrives during the handshake is therefore never lost. Internally each flag has an "armed" bit. A read that returns a one sets it. An event, or any write to the flag's byte lane, drops it.

Top module: `mbif_ctrl`

## Requirements
- R1: After reset, every flag and every enable bit is zero and `irq_o` is low.
- R2: A one on `buf_done[i]` in a cycle makes flag i read as one from the next cycle on. A flag never becomes one without such a pulse.
- R3: While `bus_sel`=1 and `bus_wr`=0, `bus_rdata` returns the addressed register combinationally in the same cycle. Address 0 selects the flags and address 1 selects the enables. Each byte lane whose `bus_be` bit is clear reads as zero. `bus_be[1]` covers bits 15:8 and `bus_be[0]` covers bits 7:0. When no read is in progress, `bus_rdata` is zero.
- R4: A write to the enable register (address 1) loads only the byte lanes whose `bus_be` bit is set. The other lane keeps its value. The enables change on no other cycle.
- R5: Writing a one to a flag bit leaves that flag unchanged.
- R6: A zero written to a flag that has not been read as one since its last event does not clear it.
- R7: A flag that was read as one and is then written as zero, with no event in between, reads as zero after the write.
- R8: A `buf_done` pulse for a buffer that arrives after its flag was read as one cancels the pending clear. The next zero write leaves the flag at one.
- R9: When a `buf_done` pulse and a qualifying zero write hit the same flag in the same cycle, the flag stays one.
- R10: A read of only one byte lane arms only the flags in that lane. A later zero write to both lanes clears only the flags that were armed.
- R11: `irq_o` is a register. In each cycle it equals the OR over all buffers of (flag AND enable) as they stood in the previous cycle.
- R12: Any write to the flag register disarms every flag in its enabled lanes, including a write of all ones. A following zero write then does not clear those flags until they are read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = flag register, 1 = enable register |
| bus_be | input | 2 | Byte lane enables, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |
| buf_done | input | 16 | Per-buffer transfer-complete pulses |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so the bench compares `bus_rdata` in the same cycle as the read strobe. Each flag or enable update from a pulse or a write becomes visible on the first read after the next clock edge. `irq_o` trails the flag and enable state by exactly one edge. To respect that lag, the bench model records its expected `irq_o` before it applies each cycle's update. The driver drives on the falling edge and queues one expected record per cycle. The monitor pops and compares that record a quarter period later, so each comparison lands in the cycle in which its result is due.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  typedef enum logic {
    REG_FLAG = 1'b0,
    REG_MASK = 1'b1
  } mbif_reg_e;
endpackage

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank #(
  parameter int NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] lane_bits,
  input  logic [NUM_BUF-1:0] wdata,
  input  logic [NUM_BUF-1:0] set_i,
  output logic [NUM_BUF-1:0] flag_q
);
  logic [NUM_BUF-1:0] armed_q;
  logic [NUM_BUF-1:0] read_arm;
  logic [NUM_BUF-1:0] write_lanes;
  logic [NUM_BUF-1:0] clr_bits;
  logic [NUM_BUF-1:0] flag_d;
  logic [NUM_BUF-1:0] armed_d;

  always_comb begin
    read_arm    = rd_en ? (flag_q & lane_bits) : '0;
    write_lanes = wr_en ? lane_bits : '0;
    // a clear needs the armed bit; an event in the same cycle overrides it
    clr_bits    = write_lanes & ~wdata & armed_q;
    flag_d      = (flag_q & ~clr_bits) | set_i;
    armed_d     = (armed_q & ~set_i & ~write_lanes) | read_arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/mbif_mask_reg.sv
module mbif_mask_reg #(
  parameter int NUM_BUF = 16,
  parameter int LANE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [NUM_BUF/LANE_W-1:0] be,
  input  logic [NUM_BUF-1:0]        wdata,
  output logic [NUM_BUF-1:0]        mask_q
);
  localparam int NUM_LANES = NUM_BUF / LANE_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g*LANE_W +: LANE_W] <= '0;
      end else if (wr_en && be[g]) begin
        mask_q[g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/mbif_irq_reduce.sv
module mbif_irq_reduce #(
  parameter int NUM_BUF = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] flag_i,
  input  logic [NUM_BUF-1:0] mask_i,
  output logic               irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag_i & mask_i);
  end
endmodule

// File: rtl/mbif_ctrl.sv
module mbif_ctrl
  import mbif_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int LANE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic                      bus_addr,
  input  logic [NUM_BUF/LANE_W-1:0] bus_be,
  input  logic [NUM_BUF-1:0]        bus_wdata,
  output logic [NUM_BUF-1:0]        bus_rdata,
  input  logic [NUM_BUF-1:0]        buf_done,
  output logic                      irq_o
);
  localparam int NUM_LANES = NUM_BUF / LANE_W;

  logic [NUM_BUF-1:0] lane_bits;
  logic [NUM_BUF-1:0] flag_q;
  logic [NUM_BUF-1:0] mask_q;
  logic               rd_any;
  logic               rd_flag;
  logic               wr_flag;
  logic               wr_mask;
  mbif_reg_e          reg_sel;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_be
    assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{bus_be[g]}};
  end

  assign reg_sel = mbif_reg_e'(bus_addr);
  assign rd_any  = bus_sel & ~bus_wr;
  assign rd_flag = rd_any & (reg_sel == REG_FLAG);
  assign wr_flag = bus_sel & bus_wr & (reg_sel == REG_FLAG);
  assign wr_mask = bus_sel & bus_wr & (reg_sel == REG_MASK);

  mbif_flag_bank #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_flag),
    .wr_en     (wr_flag),
    .lane_bits (lane_bits),
    .wdata     (bus_wdata),
    .set_i     (buf_done),
    .flag_q    (flag_q)
  );

  mbif_mask_reg #(.NUM_BUF(NUM_BUF), .LANE_W(LANE_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_mask),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .mask_q (mask_q)
  );

  mbif_irq_reduce #(.NUM_BUF(NUM_BUF)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_i (flag_q),
    .mask_i (mask_q),
    .irq_q  (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      bus_rdata = ((reg_sel == REG_MASK) ? mask_q : flag_q) & lane_bits;
    end
  end
endmodule

// File: rtl/mbif_ctrl_chk.sv
module mbif_ctrl_chk #(
  parameter int NUM_BUF = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               bus_addr,
  input logic [NUM_BUF-1:0] bus_wdata,
  input logic [NUM_BUF-1:0] lane_bits,
  input logic [NUM_BUF-1:0] buf_done,
  input logic [NUM_BUF-1:0] flag_q,
  input logic [NUM_BUF-1:0] mask_q,
  input logic               irq_o
);
  logic [NUM_BUF-1:0] zero_written;
  assign zero_written = (bus_sel && bus_wr && !bus_addr) ? (lane_bits & ~bus_wdata) : '0;

  // R2 R9
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|buf_done) |=> ((flag_q & $past(buf_done)) == $past(buf_done)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(buf_done)) == '0));

  // R5 R6
  drop_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q & ~$past(zero_written)) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr) |=> $stable(mask_q));

  // R11
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(flag_q & mask_q)));
endmodule

bind mbif_ctrl mbif_ctrl_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .lane_bits (lane_bits),
  .buf_done  (buf_done),
  .flag_q    (flag_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/tb_mbif_ctrl.sv
`timescale 1ns/1ps
module tb_mbif_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] buf_done = '0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] exp_rd_q[$];
  logic        exp_irq_q[$];
  string       tag_q[$];

  // requirement-level model
  logic [15:0] m_flag = '0, m_mask = '0, m_armed = '0;
  logic        m_irq = 1'b0;

  always #10 clk = ~clk;

  mbif_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .buf_done(buf_done), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit sel, bit wr, bit addr, logic [1:0] be,
                     logic [15:0] wd, logic [15:0] set, string tag);
    logic [15:0] lanes, rd_exp, clr;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_be = be;
    bus_wdata = wd; buf_done = set;
    lanes  = {{8{be[1]}}, {8{be[0]}}};
    rd_exp = (sel && !wr) ? ((addr ? m_mask : m_flag) & lanes) : 16'h0;
    exp_rd_q.push_back(rd_exp);
    exp_irq_q.push_back(m_irq);
    tag_q.push_back(tag);
    m_irq = |(m_flag & m_mask);
    clr = (sel && wr && !addr) ? (lanes & ~wd & m_armed) : 16'h0;
    m_armed = (m_armed & ~set & ~((sel && wr && !addr) ? lanes : 16'h0))
            | ((sel && !wr && !addr) ? (m_flag & lanes) : 16'h0);
    m_flag = (m_flag & ~clr) | set;
    if (sel && wr && addr) m_mask = (m_mask & ~lanes) | (wd & lanes);
  endtask

  task automatic rd(bit addr, logic [1:0] be, string tag);
    cyc(1, 0, addr, be, 16'h0, 16'h0, tag);
  endtask
  task automatic wr(bit addr, logic [1:0] be, logic [15:0] wd, string tag);
    cyc(1, 1, addr, be, wd, 16'h0, tag);
  endtask
  task automatic pulse(logic [15:0] set, string tag);
    cyc(0, 0, 0, 2'b00, 16'h0, set, tag);
  endtask

  // monitor: one expected record per driven cycle
  always begin
    @(negedge clk);
    #5;
    if (exp_rd_q.size() > 0) begin
      string t;
      t = tag_q.pop_front();
      check({t, " rdata"}, bus_rdata, exp_rd_q.pop_front());
      check({t, "/R11 irq"}, {15'h0, irq_o}, {15'h0, exp_irq_q.pop_front()});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {15'h0, irq_o}, 16'h0);
    rd(0, 2'b11, "R1 flags");
    rd(1, 2'b11, "R1 mask");
    // R2 set and R3 idle read zero
    pulse(16'h0081, "R3 idle");
    rd(0, 2'b11, "R2 set");
    // R5 write ones, R12 write disarms
    wr(0, 2'b11, 16'hFFFF, "R5 write1");
    wr(0, 2'b11, 16'h0000, "R12 write0");
    rd(0, 2'b11, "R12 kept");
    // R7 read then zero write clears
    wr(0, 2'b11, 16'hFF7E, "R7 write");
    rd(0, 2'b11, "R7 cleared");
    // R6 zero write with no read
    pulse(16'h0100, "R6 set");
    wr(0, 2'b11, 16'h0000, "R6 write");
    rd(0, 2'b11, "R6 kept");
    // R8 event between read and write
    pulse(16'h0100, "R8 set");
    wr(0, 2'b11, 16'h0000, "R8 write");
    rd(0, 2'b11, "R8 kept");
    // R9 same-cycle set and clear
    cyc(1, 1, 0, 2'b11, 16'h0000, 16'h0100, "R9 collide");
    rd(0, 2'b11, "R9 kept");
    // R10 byte read arms one lane
    pulse(16'h0201, "R10 set");
    rd(0, 2'b01, "R10/R3 low read");
    wr(0, 2'b11, 16'h0000, "R10 write");
    rd(0, 2'b11, "R10 result");
    rd(0, 2'b10, "R3 high read");
    // R4 mask byte writes
    wr(1, 2'b11, 16'h00F0, "R4 full");
    wr(1, 2'b10, 16'hAB55, "R4 high");
    rd(1, 2'b11, "R4 mask");
    rd(1, 2'b10, "R3 mask high");
    rd(1, 2'b01, "R3 mask low");
    // R11 irq tracks flag and mask with one cycle lag
    wr(1, 2'b11, 16'h0000, "R11 mask off");
    pulse(16'h0000, "R11 idle");
    wr(1, 2'b01, 16'h0008, "R11 mask b3");
    pulse(16'h0008, "R11 set b3");
    pulse(16'h0000, "R11 idle");
    rd(0, 2'b01, "R11 arm");
    wr(0, 2'b01, 16'h0000, "R11 clear");
    pulse(16'h0000, "R11 idle");
    pulse(16'h0000, "R11 idle");
    rd(0, 2'b11, "R11 flags");
    pulse(16'h0000, "R11 drain");
    @(negedge clk);
    #8;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule